// File: doc/BRIEF.md
# Tamper Input Sampling Filter

This block watches a single external tamper pin in a slow real-time-clock domain and raises a sticky tamper event when the pin reaches its active level. The raw pin is first brought into the clock domain through a two-flop synchronizer. After that, one of two detection schemes applies. In edge mode, any transition of the synchronized input into the active level sets the event at once. In filtered mode, a prescaler produces one sample every 2^(15−F) clock cycles, and the event fires only after a programmed number of consecutive samples have all seen the active level.

In filtered mode the block can also drive a pull-up enable for a programmed number of cycles just before each sample. This charges the external pin so that an open line reads as the idle level. The sample is taken on the cycle straight after that window, and the pull-up enable is already low on that cycle. Any change to the configuration inputs restarts the prescaler and discards partial filter progress. A one-cycle clear pulse drops the event flag and restarts the count.

Top module: `tamper_sample_filter`

## Requirements
- R1: While reset is held and on the first cycle after it, `pu_en`, `sample_stb` and `tamper_evt` are all 0.
- R2: In filtered mode (`flt_sel` ≠ 0), `sample_stb` pulses high for exactly one cycle every 2^(15−`freq_sel`) clock cycles. This gives 256 cycles for `freq_sel`=7, 512 for 6, and 32768 for 0.
- R3: In filtered mode with `pu_disable`=0, `pu_en` is high for exactly 2^`prch_sel` consecutive cycles (1, 2, 4 or 8) that end on the cycle just before each strobe. `pu_en` is 0 on the strobe cycle itself.
- R4: With `pu_disable`=1, `pu_en` stays 0 while sampling continues at the same rate.
- R5: With `flt_sel`=0 (edge mode), `pu_en` and `sample_stb` stay 0. `tamper_evt` becomes 1 on the third clock edge after the pin changes from inactive to active. A falling transition or a level that stays active causes no new event.
- R6: With `flt_sel` = 1, 2 or 3, `tamper_evt` becomes 1 on the clock edge after the strobe of the 2nd, 4th or 8th consecutive active sample, and not earlier.
- R7: A sample taken at the inactive level resets the consecutive-sample count to zero.
- R8: With `act_high`=1 the active pin level is 1. With `act_high`=0 the active level is 0.
- R9: `tamper_evt` stays 1 until `evt_clear` is pulsed, and is 0 on the cycle after the pulse. After a clear, a full fresh run of active samples is needed to fire again.
- R10: Any change to `act_high`, `freq_sel`, `flt_sel`, `prch_sel` or `pu_disable` restarts the prescaler and zeroes the sample count. The next strobe then comes one full new period after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Low-frequency real-time clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_raw | input | 1 | Unsynchronized tamper pin level |
| act_high | input | 1 | 1: pin active high, 0: active low |
| freq_sel | input | 3 | Sample period select, period = 2^(15−value) cycles |
| flt_sel | input | 2 | 0: edge mode; 1/2/3: need 2/4/8 consecutive active samples |
| prch_sel | input | 2 | Pull-up window length 2^value cycles |
| pu_disable | input | 1 | 1: skip the pull-up window |
| evt_clear | input | 1 | One-cycle pulse that clears the event |
| pu_en | output | 1 | Pull-up (precharge) enable for the pin |
| sample_stb | output | 1 | High on each cycle a filtered sample is taken |
| tamper_evt | output | 1 | Sticky tamper event flag |

## Verification
The bench measures the exact cycle gap between strobes at three rates. It also measures the length of the pull-up window right before a strobe, so a window that overlaps the sample, or one that is off by a cycle, shows up as a wrong count. In filtered mode it counts samples to the firing point and breaks runs with a single inactive sample. It also keeps the pin active across a clear and across a configuration change. A design that leaked its count past either of those would fire one sample early. Edge mode is checked for the exact synchronizer latency, and for staying silent both on a held level and on a falling edge.

// File: rtl/tsf_pkg.sv
package tsf_pkg;
    localparam int FREQ_W       = 3;
    localparam int FLT_W        = 2;
    localparam int PRCH_W       = 2;
    localparam int DIV_LOG2_MAX = 15;
    localparam int CNT_W        = DIV_LOG2_MAX;
    localparam int RUN_W        = (1 << FLT_W);
    localparam int PRE_W        = (1 << PRCH_W);
    localparam int SYNC_STAGES  = 2;

    typedef struct packed {
        logic              act_high;
        logic [FREQ_W-1:0] freq;
        logic [FLT_W-1:0]  flt;
        logic [PRCH_W-1:0] prch;
        logic              pu_dis;
    } tsf_cfg_t;
endpackage

// File: rtl/tsf_sync.sv
module tsf_sync #(
    parameter int STAGES = tsf_pkg::SYNC_STAGES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/tsf_prescaler.sv
module tsf_prescaler
    import tsf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FREQ_W-1:0] freq,
    input  logic [PRCH_W-1:0] prch,
    input  logic              pu_dis,
    input  logic              filt_mode,
    input  logic              restart,
    output logic              pu_en,
    output logic              stb
);
    localparam int SH_W = $clog2(DIV_LOG2_MAX + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } psc_st_t;

    psc_st_t st_d, st_q;

    logic [CNT_W:0]   span;
    logic [CNT_W-1:0] last;
    logic [PRE_W-1:0] pre_len;
    logic [CNT_W-1:0] pre_start;

    always_comb begin
        span      = (CNT_W+1)'(1) << (SH_W'(DIV_LOG2_MAX) - SH_W'(freq));
        last      = CNT_W'(span - (CNT_W+1)'(1));
        pre_len   = PRE_W'(1) << prch;
        pre_start = last - CNT_W'(pre_len);

        st_d = st_q;
        if (restart || st_q.cnt >= last) st_d.cnt = '0;
        else                             st_d.cnt = st_q.cnt + CNT_W'(1);

        stb   = filt_mode && !restart && (st_q.cnt == last);
        pu_en = filt_mode && !restart && !pu_dis &&
                (st_q.cnt >= pre_start) && (st_q.cnt < last);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2: a strobe always ends the period, the next cycle starts at zero
    a_r2_wrap_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        stb |=> (st_q.cnt == '0));

    // R3: a sample with precharge enabled is preceded by a charged cycle
    a_r3_charge_before_sample: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && !pu_dis) |-> $past(pu_en));
endmodule

// File: rtl/tsf_filter.sv
module tsf_filter
    import tsf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lvl,
    input  logic             act_high,
    input  logic [FLT_W-1:0] flt,
    input  logic             filt_mode,
    input  logic             stb,
    input  logic             restart,
    input  logic             clr,
    output logic             evt
);
    typedef struct packed {
        logic [RUN_W-1:0] run;
        logic             prev_act;
        logic             evt;
    } flt_st_t;

    flt_st_t st_d, st_q;

    logic             act;
    logic [RUN_W-1:0] need;
    logic [RUN_W-1:0] run_inc;

    always_comb begin
        act     = (lvl == act_high);
        need    = RUN_W'(1) << flt;
        run_inc = st_q.run + RUN_W'(1);

        st_d          = st_q;
        st_d.prev_act = act;
        if (clr) begin
            st_d.evt = 1'b0;
            st_d.run = '0;
        end else if (restart) begin
            st_d.run = '0;
        end else if (filt_mode) begin
            if (stb) begin
                if (act) begin
                    if (run_inc >= need) begin
                        st_d.evt = 1'b1;
                        st_d.run = need;
                    end else begin
                        st_d.run = run_inc;
                    end
                end else begin
                    st_d.run = '0;
                end
            end
        end else if (act && !st_q.prev_act) begin
            st_d.evt = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{run: '0, prev_act: 1'b1, evt: 1'b0};
        else        st_q <= st_d;
    end

    assign evt = st_q.evt;

    // R9: the flag holds without a clear
    a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.evt && !clr) |=> st_q.evt);

    // R9: a clear drops the flag on the next cycle
    a_r9_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !st_q.evt);

    // R7: an inactive sample leaves the run count at zero
    a_r7_inactive_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && !act && !restart && !clr) |=> (st_q.run == '0));

    // R6: in filtered mode the flag only rises right after a sample
    a_r6_rise_on_sample: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(st_q.evt) && $past(filt_mode)) |-> $past(stb));
endmodule

// File: rtl/tamper_sample_filter.sv
module tamper_sample_filter
    import tsf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin_raw,
    input  logic              act_high,
    input  logic [FREQ_W-1:0] freq_sel,
    input  logic [FLT_W-1:0]  flt_sel,
    input  logic [PRCH_W-1:0] prch_sel,
    input  logic              pu_disable,
    input  logic              evt_clear,
    output logic              pu_en,
    output logic              sample_stb,
    output logic              tamper_evt
);
    tsf_cfg_t cfg_in, cfg_d, cfg_q;
    logic     cfg_chg;
    logic     filt_mode;
    logic     lvl_sync;

    always_comb begin
        cfg_in = '{act_high: act_high, freq: freq_sel, flt: flt_sel,
                   prch: prch_sel, pu_dis: pu_disable};
        cfg_chg   = (cfg_in != cfg_q);
        filt_mode = (cfg_q.flt != '0);
        cfg_d     = cfg_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    tsf_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pin_raw),
        .dout (lvl_sync)
    );

    tsf_prescaler u_psc (
        .clk      (clk),
        .rst_n    (rst_n),
        .freq     (cfg_q.freq),
        .prch     (cfg_q.prch),
        .pu_dis   (cfg_q.pu_dis),
        .filt_mode(filt_mode),
        .restart  (cfg_chg),
        .pu_en    (pu_en),
        .stb      (sample_stb)
    );

    tsf_filter u_flt (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl      (lvl_sync),
        .act_high (cfg_q.act_high),
        .flt      (cfg_q.flt),
        .filt_mode(filt_mode),
        .stb      (sample_stb),
        .restart  (cfg_chg),
        .clr      (evt_clear),
        .evt      (tamper_evt)
    );

    // R5: edge mode keeps pull-up and sampling idle
    a_r5_edge_mode_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.flt == '0) |-> (!pu_en && !sample_stb));

    // R4: disabled precharge never drives the pull-up
    a_r4_no_pullup: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.pu_dis |-> !pu_en);

    // R3: pull-up and sample never share a cycle
    a_r3_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
        !(pu_en && sample_stb));
endmodule

// File: tb/tb_tamper_sample_filter.sv
module tb_tamper_sample_filter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin_raw = 1'b0;
    logic       act_high = 1'b1;
    logic [2:0] freq_sel = 3'd0;
    logic [1:0] flt_sel = 2'd0;
    logic [1:0] prch_sel = 2'd0;
    logic       pu_disable = 1'b0;
    logic       evt_clear = 1'b0;
    logic       pu_en, sample_stb, tamper_evt;

    int n_chk = 0;
    int n_fail = 0;
    int g_gap, g_run, g_seen, g_pu_at;

    always #2.5 clk = ~clk;

    tamper_sample_filter dut (
        .clk(clk), .rst_n(rst_n), .pin_raw(pin_raw), .act_high(act_high),
        .freq_sel(freq_sel), .flt_sel(flt_sel), .prch_sel(prch_sel),
        .pu_disable(pu_disable), .evt_clear(evt_clear),
        .pu_en(pu_en), .sample_stb(sample_stb), .tamper_evt(tamper_evt)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_stb();
        g_gap = 0; g_run = 0; g_seen = 0; g_pu_at = 0;
        while (g_gap < 40000) begin
            @(negedge clk);
            g_gap++;
            if (sample_stb) begin
                g_pu_at = int'(pu_en);
                break;
            end
            if (pu_en) begin g_run++; g_seen++; end
            else g_run = 0;
        end
    endtask

    task automatic set_cfg(input bit ah, input int f, input int fl, input int pr, input bit pd);
        @(negedge clk);
        act_high = ah; freq_sel = 3'(f); flt_sel = 2'(fl); prch_sel = 2'(pr); pu_disable = pd;
    endtask

    task automatic clear_evt();
        @(negedge clk);
        evt_clear = 1'b1;
        @(negedge clk);
        evt_clear = 1'b0;
    endtask

    task automatic t_reset();
        #1;
        chk(!pu_en && !sample_stb && !tamper_evt, "R1 outputs in reset", {pu_en, sample_stb, tamper_evt}, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!pu_en && !sample_stb && !tamper_evt, "R1 outputs after reset", {pu_en, sample_stb, tamper_evt}, 0);
    endtask

    task automatic t_period();
        set_cfg(1, 7, 1, 0, 0);
        wait_stb();
        wait_stb();
        chk(g_gap == 256, "R2 period F=7", g_gap, 256);
        chk(g_run == 1 && g_pu_at == 0, "R3 precharge 1 cycle", g_run, 1);
        set_cfg(1, 6, 1, 0, 0);
        wait_stb();
        wait_stb();
        chk(g_gap == 512, "R2 period F=6", g_gap, 512);
    endtask

    task automatic t_precharge();
        set_cfg(1, 7, 1, 3, 0);
        wait_stb();
        wait_stb();
        chk(g_run == 8 && g_seen == 8, "R3 precharge 8 cycles", g_run, 8);
        chk(g_pu_at == 0, "R3 pull-up low on strobe", g_pu_at, 0);
        set_cfg(1, 7, 1, 2, 0);
        wait_stb();
        wait_stb();
        chk(g_run == 4 && g_seen == 4, "R3 precharge 4 cycles", g_run, 4);
        set_cfg(1, 7, 1, 3, 1);
        wait_stb();
        wait_stb();
        chk(g_seen == 0, "R4 pull-up disabled", g_seen, 0);
        chk(g_gap == 256, "R4 sampling rate kept", g_gap, 256);
    endtask

    task automatic t_filter_count();
        set_cfg(1, 7, 2, 0, 0);
        clear_evt();
        pin_raw = 1'b1;
        for (int i = 0; i < 3; i++) wait_stb();
        @(negedge clk);
        chk(tamper_evt == 0, "R6 no event after 3 of 4", tamper_evt, 0);
        wait_stb();
        chk(tamper_evt == 0, "R6 not set on strobe cycle", tamper_evt, 0);
        @(negedge clk);
        chk(tamper_evt == 1, "R6 event after 4 samples", tamper_evt, 1);
        pin_raw = 1'b0;
        wait_stb();
        @(negedge clk);
        chk(tamper_evt == 1, "R9 flag sticky", tamper_evt, 1);
        clear_evt();
        chk(tamper_evt == 0, "R9 flag cleared", tamper_evt, 0);
    endtask

    task automatic t_clear_restart();
        set_cfg(1, 7, 1, 0, 0);
        clear_evt();
        pin_raw = 1'b1;
        wait_stb();
        wait_stb();
        @(negedge clk);
        chk(tamper_evt == 1, "R6 event after 2 samples", tamper_evt, 1);
        clear_evt();
        wait_stb();
        @(negedge clk);
        chk(tamper_evt == 0, "R9 count restarts after clear", tamper_evt, 0);
        wait_stb();
        @(negedge clk);
        chk(tamper_evt == 1, "R9 fires after fresh run", tamper_evt, 1);
        pin_raw = 1'b0;
        clear_evt();
    endtask

    task automatic t_run_reset();
        set_cfg(1, 7, 1, 0, 0);
        clear_evt();
        pin_raw = 1'b1;
        wait_stb();
        pin_raw = 1'b0;
        wait_stb();
        pin_raw = 1'b1;
        wait_stb();
        @(negedge clk);
        chk(tamper_evt == 0, "R7 inactive sample breaks run", tamper_evt, 0);
        wait_stb();
        @(negedge clk);
        chk(tamper_evt == 1, "R7 fires after unbroken run", tamper_evt, 1);
        pin_raw = 1'b0;
        clear_evt();
    endtask

    task automatic t_polarity();
        pin_raw = 1'b1;
        set_cfg(0, 7, 1, 0, 0);
        clear_evt();
        wait_stb();
        wait_stb();
        wait_stb();
        @(negedge clk);
        chk(tamper_evt == 0, "R8 high pin inactive when active-low", tamper_evt, 0);
        pin_raw = 1'b0;
        wait_stb();
        wait_stb();
        @(negedge clk);
        chk(tamper_evt == 1, "R8 low pin fires when active-low", tamper_evt, 1);
        pin_raw = 1'b1;
        clear_evt();
        set_cfg(1, 7, 1, 0, 0);
        pin_raw = 1'b0;
    endtask

    task automatic t_cfg_change();
        set_cfg(1, 7, 1, 0, 0);
        clear_evt();
        pin_raw = 1'b1;
        wait_stb();
        repeat (100) @(negedge clk);
        freq_sel = 3'd6;
        wait_stb();
        chk(g_gap == 512, "R10 prescaler restarted", g_gap, 512);
        @(negedge clk);
        chk(tamper_evt == 0, "R10 run cleared by change", tamper_evt, 0);
        wait_stb();
        @(negedge clk);
        chk(tamper_evt == 1, "R10 fires after new run", tamper_evt, 1);
        pin_raw = 1'b0;
        clear_evt();
    endtask

    task automatic t_edge();
        int stb_n = 0;
        int pu_n = 0;
        pin_raw = 1'b0;
        set_cfg(1, 7, 0, 3, 0);
        clear_evt();
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if (sample_stb) stb_n++;
            if (pu_en) pu_n++;
        end
        chk(stb_n == 0 && pu_n == 0, "R5 edge mode idle", stb_n + pu_n, 0);
        chk(tamper_evt == 0, "R5 no event while inactive", tamper_evt, 0);
        pin_raw = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(tamper_evt == 0, "R5 event not before sync", tamper_evt, 0);
        @(negedge clk);
        chk(tamper_evt == 1, "R5 event on rising edge", tamper_evt, 1);
        clear_evt();
        repeat (20) @(negedge clk);
        chk(tamper_evt == 0, "R5 held level no retrigger", tamper_evt, 0);
        pin_raw = 1'b0;
        repeat (10) @(negedge clk);
        chk(tamper_evt == 0, "R5 falling edge ignored", tamper_evt, 0);
        pin_raw = 1'b1;
        repeat (3) @(negedge clk);
        chk(tamper_evt == 1, "R5 second rising edge", tamper_evt, 1);
        pin_raw = 1'b0;
        clear_evt();
    endtask

    task automatic t_slow();
        set_cfg(1, 0, 1, 0, 0);
        wait_stb();
        wait_stb();
        chk(g_gap == 32768, "R2 period F=0", g_gap, 32768);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog all requirements actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        t_reset();
        t_period();
        t_precharge();
        t_filter_count();
        t_clear_restart();
        t_run_reset();
        t_polarity();
        t_cfg_change();
        t_edge();
        t_slow();
        finish_run();
    end
endmodule